// File: doc/BRIEF.md
# Windowed Register File

This block holds a processor's integer registers behind a sliding window. Code addresses 32 architectural registers with 5-bit names. A current-window pointer turns each name into an index in a physical array that is much larger than 32 entries. The array has one write port and a parameterised number of read ports. Each port takes an architectural name and translates it with the pointer's current value.

Names 0 to 7 are shared globals and always reach the same eight physical entries. Names 8 to 31 form a 24-register window made of three groups: outgoing (8 to 15), local (16 to 23) and incoming (24 to 31). A save pulse moves the window forward by one step of 16 physical entries, and a restore pulse moves it back. Each move takes one clock. Because the step is 16 while a window holds 24 registers, the outgoing group of one window is the same storage as the incoming group of the next. A caller can therefore pass arguments to a callee without copying them. The windowed part of the array is circular, so the last window's outgoing group is the first window's incoming group.

Top module: `regwin_file`

## Requirements
- R1: While reset is held and after it is released, `cwp` is 0 and every register reads 0 on every read port.
- R2: A cycle with `save` high and `restore` low sets `cwp` to `cwp+1` at the next rising edge. `NWIN-1` wraps to 0.
- R3: A cycle with `restore` high and `save` low sets `cwp` to `cwp-1` at the next rising edge. 0 wraps to `NWIN-1`.
- R4: `save` and `restore` both high, or both low, leave `cwp` unchanged.
- R5: Names 0 to 7 map to physical entries 0 to 7 whatever `cwp` is. A value written to a global reads back the same from every window.
- R6: A windowed name n in window c maps to physical entry `8 + ((16*c + k) mod (16*NWIN))`. Here k is n-24 for names 24 to 31, n-8 for names 16 to 23, and n+8 for names 8 to 15. With seven windows, name 20 therefore reaches entries 20, 36, 52, 68, 84, 100 and 116.
- R7: The outgoing name n (8 to 15) of window c is the same storage as the incoming name n+16 of window (c+1) mod `NWIN`. This includes the wrap from the last window to window 0.
- R8: A write takes effect at the rising edge and uses the `cwp` value of that cycle, even when `save` or `restore` is high in the same cycle. The read ports are combinational and show the old value until that edge.
- R9: Every read port returns the contents of the entry its own name selects under the current `cwp`, independently of the other ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| save | input | 1 | Advance window pointer |
| restore | input | 1 | Retreat window pointer |
| cwp | output | CW | Current window pointer |
| wr_en | input | 1 | Write enable |
| wr_name | input | 5 | Architectural name to write |
| wr_data | input | WIDTH | Write data |
| rd_name | input | 5*NRD | Architectural names, one 5-bit field per read port, port 0 in the low bits |
| rd_data | output | WIDTH*NRD | Read data, one field per read port, port 0 in the low bits |

## Verification
A faulty pointer update shows on `cwp` at the edge right after the offending save or restore. A faulty translation is quieter. A value then lands in the wrong physical entry, and the error shows only when some window reads a name that aliases that entry, possibly several window moves later. For that reason the bench fills all 32 names in every window before it reads anything back. It then reads every name on two ports in every window against a model of the physical array, so misplaced or missing aliasing appears as a stale or overwritten value. Writes that coincide with a window move are checked across the move, including the wrap from the last window to the first.

// File: rtl/regwin_file.sv
module regwin_file #(
  parameter int WIDTH = 32,
  parameter int NWIN  = 7,
  parameter int NRD   = 2,
  localparam int NGLB  = 8,
  localparam int STEP  = 16,
  localparam int NWREG = STEP * NWIN,
  localparam int NPHYS = NGLB + NWREG,
  localparam int PW    = $clog2(NPHYS),
  localparam int CW    = $clog2(NWIN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 save,
  input  logic                 restore,
  output logic [CW-1:0]        cwp,
  input  logic                 wr_en,
  input  logic [4:0]           wr_name,
  input  logic [WIDTH-1:0]     wr_data,
  input  logic [5*NRD-1:0]     rd_name,
  output logic [WIDTH*NRD-1:0] rd_data
);

  function automatic logic [PW-1:0] to_phys(input logic [4:0] name, input logic [CW-1:0] win);
    int n, k;
    n = int'(name);
    if (n < NGLB) return PW'(n);
    if (n >= 24)      k = n - 24;
    else if (n >= 16) k = n - 8;
    else              k = n + 8;
    return PW'(NGLB + ((STEP * int'(win) + k) % NWREG));
  endfunction

  logic [WIDTH-1:0] mem [NPHYS];
  logic [PW-1:0]    wr_idx;
  logic [CW-1:0]    cwp_up, cwp_dn;

  assign wr_idx = to_phys(wr_name, cwp);
  assign cwp_up = (cwp == CW'(NWIN - 1)) ? '0 : cwp + 1'b1;
  assign cwp_dn = (cwp == '0) ? CW'(NWIN - 1) : cwp - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cwp <= '0;
    else if (save && !restore) cwp <= cwp_up;
    else if (restore && !save) cwp <= cwp_dn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g*WIDTH +: WIDTH] = mem[to_phys(rd_name[g*5 +: 5], cwp)];
  end

endmodule

// File: rtl/regwin_file_chk.sv
module regwin_file_chk #(
  parameter int WIDTH = 32,
  parameter int NWIN  = 7,
  parameter int NRD   = 2,
  localparam int CW   = $clog2(NWIN)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 save,
  input logic                 restore,
  input logic [CW-1:0]        cwp,
  input logic                 wr_en,
  input logic [4:0]           wr_name,
  input logic [WIDTH-1:0]     wr_data,
  input logic [5*NRD-1:0]     rd_name,
  input logic [WIDTH*NRD-1:0] rd_data
);

  always_comb begin
    if (!rst_n) assert_reset_ptr_R1: assert (cwp == '0);
  end

  assert_ptr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cwp) < NWIN);

  assert_save_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (save && !restore) |=>
      cwp == (($past(cwp) == CW'(NWIN - 1)) ? CW'(0) : CW'($past(cwp) + 1'b1)));

  assert_restore_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (restore && !save) |=>
      cwp == (($past(cwp) == CW'(0)) ? CW'(NWIN - 1) : CW'($past(cwp) - 1'b1)));

  assert_hold_ptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (save == restore) |=> $stable(cwp));

  assert_write_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && save == restore) |=>
      (rd_name[4:0] != $past(wr_name) || rd_data[WIDTH-1:0] == $past(wr_data)));

  assert_global_any_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_name < 5'd8) |=>
      (rd_name[4:0] != $past(wr_name) || rd_data[WIDTH-1:0] == $past(wr_data)));

  assert_out_to_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && save && !restore && wr_name >= 5'd8 && wr_name < 5'd16) |=>
      (rd_name[4:0] != $past(wr_name) + 5'd16 || rd_data[WIDTH-1:0] == $past(wr_data)));

endmodule

bind regwin_file regwin_file_chk #(.WIDTH(WIDTH), .NWIN(NWIN), .NRD(NRD)) u_chk (
  .clk(clk), .rst_n(rst_n), .save(save), .restore(restore), .cwp(cwp),
  .wr_en(wr_en), .wr_name(wr_name), .wr_data(wr_data),
  .rd_name(rd_name), .rd_data(rd_data)
);

// File: tb/test_regwin_file.sv
module test_regwin_file;
  localparam int WIDTH = 32;
  localparam int NWIN  = 7;
  localparam int NRD   = 2;
  localparam int NWREG = 16 * NWIN;
  localparam int NPHYS = 8 + NWREG;
  localparam int CW    = $clog2(NWIN);

  logic clk = 0, rst_n = 0, save = 0, restore = 0, wr_en = 0;
  logic [4:0] wr_name = '0;
  logic [WIDTH-1:0] wr_data = '0;
  logic [5*NRD-1:0] rd_name = '0;
  logic [WIDTH*NRD-1:0] rd_data;
  logic [CW-1:0] cwp;

  int checks = 0, errors = 0, mwin = 0;
  logic [WIDTH-1:0] model [NPHYS];

  always #5 clk = ~clk;

  regwin_file #(.WIDTH(WIDTH), .NWIN(NWIN), .NRD(NRD)) i_regwin_file (
    .clk(clk), .rst_n(rst_n), .save(save), .restore(restore), .cwp(cwp),
    .wr_en(wr_en), .wr_name(wr_name), .wr_data(wr_data),
    .rd_name(rd_name), .rd_data(rd_data));

  function automatic int phys(input int n, input int w);
    int k;
    if (n < 8) return n;
    k = (n >= 24) ? n - 24 : (n >= 16) ? n - 8 : n + 8;
    return 8 + ((16 * w + k) % NWREG);
  endfunction

  task automatic check(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic sv, input logic rs, input logic we,
                       input int nm, input logic [WIDTH-1:0] d);
    @(negedge clk);
    save = sv; restore = rs; wr_en = we; wr_name = 5'(nm); wr_data = d;
    @(posedge clk);
    if (we) model[phys(nm, mwin)] = d;
    if (sv && !rs) mwin = (mwin + 1) % NWIN;
    if (rs && !sv) mwin = (mwin + NWIN - 1) % NWIN;
    #1;
    save = 0; restore = 0; wr_en = 0;
  endtask

  task automatic read2(input int a, input int b);
    rd_name = {5'(b), 5'(a)};
    #1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NPHYS; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset cwp", WIDTH'(cwp), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 cwp after release", WIDTH'(cwp), 0);
    for (int n = 0; n < 32; n++) begin
      read2(n, 31 - n);
      check("R1 reset data p0", rd_data[WIDTH-1:0], '0);
      check("R1 reset data p1", rd_data[2*WIDTH-1:WIDTH], '0);
    end

    // R6 mapping example: local 20 lands on 20+16c
    for (int w = 0; w < NWIN; w++)
      check("R6 name20 index", WIDTH'(phys(20, w)), WIDTH'(20 + 16 * w));

    // fill every name in every window, then read all back (R5 R6 R7 R9)
    for (int w = 0; w < NWIN; w++) begin
      for (int n = 0; n < 32; n++)
        cycle(0, 0, 1, n, 32'hC000_0000 | (w << 8) | n);
      cycle(1, 0, 0, 0, '0);
      check("R2 save step", WIDTH'(cwp), WIDTH'((w + 1) % NWIN));
    end
    for (int w = 0; w < NWIN; w++) begin
      for (int n = 0; n < 32; n++) begin
        read2(n, 31 - n);
        check(n < 8 ? "R5 global p0" : "R6 R7 window p0", rd_data[WIDTH-1:0], model[phys(n, w)]);
        check("R9 port1", rd_data[2*WIDTH-1:WIDTH], model[phys(31 - n, w)]);
      end
      cycle(1, 0, 0, 0, '0);
    end
    check("R2 wrap to 0", WIDTH'(cwp), 0);

    cycle(0, 1, 0, 0, '0);
    check("R3 wrap to last", WIDTH'(cwp), WIDTH'(NWIN - 1));
    cycle(0, 1, 0, 0, '0);
    check("R3 restore step", WIDTH'(cwp), WIDTH'(NWIN - 2));
    cycle(1, 1, 0, 0, '0);
    check("R4 both held", WIDTH'(cwp), WIDTH'(NWIN - 2));
    cycle(0, 0, 0, 0, '0);
    check("R4 neither held", WIDTH'(cwp), WIDTH'(NWIN - 2));

    // write with save in the same cycle, across the last-to-first wrap
    cycle(1, 0, 0, 0, '0);
    check("R2 to last", WIDTH'(cwp), WIDTH'(NWIN - 1));
    cycle(1, 0, 1, 12, 32'h5A5A_0012);
    check("R2 wrap with write", WIDTH'(cwp), 0);
    read2(28, 12);
    check("R7 R8 out becomes in across wrap", rd_data[WIDTH-1:0], 32'h5A5A_0012);
    check("R8 new out untouched", rd_data[2*WIDTH-1:WIDTH], model[phys(12, 0)]);
    cycle(0, 1, 0, 0, '0);
    read2(12, 12);
    check("R7 back in last window", rd_data[WIDTH-1:0], 32'h5A5A_0012);

    // write with restore in the same cycle uses the old window
    cycle(0, 1, 1, 30, 32'h7777_0030);
    read2(14, 30);
    check("R8 write before restore", rd_data[WIDTH-1:0], 32'h7777_0030);
    check("R8 model agrees", rd_data[WIDTH-1:0], model[phys(14, mwin)]);

    // read port shows old data until the edge
    read2(5, 5);
    @(negedge clk);
    wr_en = 1; wr_name = 5'd5; wr_data = 32'h0BAD_F00D;
    #1;
    check("R8 old before edge", rd_data[WIDTH-1:0], model[5]);
    @(posedge clk);
    model[5] = 32'h0BAD_F00D;
    #1;
    wr_en = 0;
    check("R8 new after edge", rd_data[WIDTH-1:0], 32'h0BAD_F00D);
    cycle(1, 0, 0, 0, '0);
    read2(5, 0);
    check("R5 global after move", rd_data[WIDTH-1:0], 32'h0BAD_F00D);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule